// File: doc/BRIEF.md
# Keyboard Controller Host Port

This block is the processor-facing side of a PC-style controller for a keyboard and an auxiliary pointing device. The host sees two byte-wide ports: a command port, whose read value is the status byte, and a data port. Command bytes are decoded at once. Some act on internal state, some answer with a reply byte, and some arm a pending command that decides what the next data-port byte does.

The block holds the mode byte, the self-test flag of the status byte and the output-port byte. It drives the A20 gate, a one-cycle system reset request, a scancode-translation enable and the two interrupt lines. Reply bytes and host-loaded buffer bytes leave through a push interface tagged keyboard or auxiliary. Bytes meant for the serial devices leave through a second one-cycle strobe interface. The byte queues and the serial protocols sit outside and report only whether each queue holds data. Every register effect, push and strobe appears in the cycle after the write edge.

Top module: `kbc_host_port`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte reads 0x18 with both queues empty, the output port is 0x03 (A20 high), the translation enable is low and no command is armed.
- R2: A command byte whose upper nibble is 0xF produces a one-cycle `sysResetReq` pulse when bit 0 is 0, and has no effect when bit 0 is 1.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending command. The next data-port write is handled according to that command, and the pending command is then cleared, so a second data byte goes to the keyboard.
- R4: A data-port write with no pending command produces a one-cycle `devWrValid` with `devWrAux`=0 and the byte on `devWrData`.
- R5: Command 0x20 pushes the mode byte. Command 0xD0 pushes the output port, with bit 4 replaced by "any queue holds data" and bit 5 by "only the auxiliary queue holds data". Commands 0xA9, 0xAB and 0xC0 push 0x00. All these pushes go to the keyboard side (`pushAux`=0), and a push never coincides with a device strobe.
- R6: Command 0xAA sets status bit 2 and pushes 0x55.
- R7: Commands 0xA7/0xA8 set/clear mode bit 5. Commands 0xAD/0xAE set/clear mode bit 4. `irqKbd` is high only while the keyboard queue holds data, mode bit 0 is 1 and mode bit 4 is 0.
- R8: Command 0xDF sets output-port bit 1 and raises `a20Gate`. Command 0xDD clears the bit and lowers it.
- R9: A data byte under 0xD1 replaces the output port. `a20Gate` follows its bit 1, and a reset pulse is issued when its bit 0 is 0.
- R10: A data byte under 0x60 replaces the mode byte, and `xlatEn` follows mode bit 6.
- R11: Status bit 0 = either queue holds data. Status bit 5 = only the auxiliary queue holds data. `irqAux` = status bit 5 and mode bit 1. A data byte under 0xD2/0xD3 is pushed to the keyboard/auxiliary side.
- R12: Any other command byte changes no state and produces no push, strobe or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrSel | input | 1 | 1 = command port, 0 = data port |
| wrData | input | 8 | Written byte |
| kbdAvail | input | 1 | Keyboard-side queue holds data |
| auxAvail | input | 1 | Auxiliary-side queue holds data |
| statusByte | output | 8 | Command-port read value |
| pushValid | output | 1 | One-cycle push of a reply byte |
| pushAux | output | 1 | Push targets the auxiliary queue |
| pushData | output | 8 | Pushed byte |
| devWrValid | output | 1 | One-cycle byte toward a serial device |
| devWrAux | output | 1 | Device byte targets the auxiliary device |
| devWrData | output | 8 | Device byte |
| a20Gate | output | 1 | A20 gate level |
| sysResetReq | output | 1 | One-cycle system reset request |
| xlatEn | output | 1 | Scancode translation enable |
| irqKbd | output | 1 | Keyboard interrupt level |
| irqAux | output | 1 | Auxiliary interrupt level |

## Verification
Interrupt gating and queue status can change together in one cycle, and the bench tests this in two ways. A mode write that clears the keyboard-interrupt enable, or a 0xAD disable, lands while the keyboard queue reports data. The bench also changes the queue flags on the same edge as a 0xD0 read. The reference model takes the availability sampled at that edge for the pushed byte and the freshly written mode for the interrupt lines. On every clock it compares status, interrupt lines and the pushed byte against the model.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // reply byte sources
  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_MODE = 3'd1,
    SRC_PORT = 3'd2,
    SRC_TEST = 3'd3,
    SRC_DATA = 3'd4
  } push_src_e;

  // control to datapath strobes
  typedef struct packed {
    logic      modeLoad;
    logic      outLoad;
    byte_t     modeSet;
    byte_t     modeClr;
    logic      a20On;
    logic      a20Off;
    logic      selfTest;
    logic      resetReq;
    logic      push;
    logic      pushAux;
    push_src_e src;
    logic      devWr;
    logic      devAux;
  } kbc_strobe_t;

  localparam byte_t MODE_RST  = 8'h03;
  localparam byte_t STAT_RST  = 8'h18;
  localparam byte_t PORT_RST  = 8'h03;
  localparam byte_t TEST_OK   = 8'h55;
  localparam byte_t KB_OFF_M  = 8'h10;
  localparam byte_t AUX_OFF_M = 8'h20;

  // immediate commands
  localparam byte_t OP_RD_MODE  = 8'h20;
  localparam byte_t OP_AUX_OFF  = 8'hA7;
  localparam byte_t OP_AUX_ON   = 8'hA8;
  localparam byte_t OP_AUX_CHK  = 8'hA9;
  localparam byte_t OP_SELF     = 8'hAA;
  localparam byte_t OP_KB_CHK   = 8'hAB;
  localparam byte_t OP_KB_OFF   = 8'hAD;
  localparam byte_t OP_KB_ON    = 8'hAE;
  localparam byte_t OP_RD_IN    = 8'hC0;
  localparam byte_t OP_RD_PORT  = 8'hD0;
  localparam byte_t OP_A20_OFF  = 8'hDD;
  localparam byte_t OP_A20_ON   = 8'hDF;
  localparam byte_t OP_PULSE_RS = 8'hFE;
  localparam byte_t OP_PULSE_NO = 8'hFF;
  // argument-taking commands
  localparam byte_t ARG_MODE    = 8'h60;
  localparam byte_t ARG_PORT    = 8'hD1;
  localparam byte_t ARG_KBUF    = 8'hD2;
  localparam byte_t ARG_ABUF    = 8'hD3;
  localparam byte_t ARG_ADEV    = 8'hD4;
endpackage

// File: rtl/kbc_decode.sv
module kbc_decode
  import kbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  byte_t       wrData,
  output kbc_strobe_t strb
);
  byte_t pendCmd;
  byte_t foldCmd;
  logic  cmdWr, dataWr, armCmd;

  assign cmdWr  = wrEn && wrSel;
  assign dataWr = wrEn && !wrSel;

  // pulse family folds to reset or no-op
  always_comb begin
    if (wrData[BYTE_W-1 -: 4] == 4'hF) foldCmd = wrData[0] ? OP_PULSE_NO : OP_PULSE_RS;
    else                               foldCmd = wrData;
  end

  assign armCmd = (foldCmd == ARG_MODE) || (foldCmd == ARG_PORT) || (foldCmd == ARG_KBUF) ||
                  (foldCmd == ARG_ABUF) || (foldCmd == ARG_ADEV);

  always_ff @(posedge clk) begin
    if (!rstN)                 pendCmd <= '0;
    else if (cmdWr && armCmd)  pendCmd <= foldCmd;
    else if (dataWr)           pendCmd <= '0;
  end

  always_comb begin
    strb = '0;
    if (cmdWr) begin
      case (foldCmd)
        OP_RD_MODE: begin strb.push = 1'b1; strb.src = SRC_MODE; end
        OP_RD_PORT: begin strb.push = 1'b1; strb.src = SRC_PORT; end
        OP_AUX_CHK, OP_KB_CHK, OP_RD_IN: begin strb.push = 1'b1; strb.src = SRC_ZERO; end
        OP_SELF:    begin strb.selfTest = 1'b1; strb.push = 1'b1; strb.src = SRC_TEST; end
        OP_AUX_OFF: strb.modeSet = AUX_OFF_M;
        OP_AUX_ON:  strb.modeClr = AUX_OFF_M;
        OP_KB_OFF:  strb.modeSet = KB_OFF_M;
        OP_KB_ON:   strb.modeClr = KB_OFF_M;
        OP_A20_ON:  strb.a20On = 1'b1;
        OP_A20_OFF: strb.a20Off = 1'b1;
        OP_PULSE_RS: strb.resetReq = 1'b1;
        default: ;
      endcase
    end else if (dataWr) begin
      case (pendCmd)
        8'h00:    begin strb.devWr = 1'b1; strb.devAux = 1'b0; end
        ARG_MODE: strb.modeLoad = 1'b1;
        ARG_PORT: strb.outLoad = 1'b1;
        ARG_KBUF: begin strb.push = 1'b1; strb.src = SRC_DATA; end
        ARG_ABUF: begin strb.push = 1'b1; strb.pushAux = 1'b1; strb.src = SRC_DATA; end
        ARG_ADEV: begin strb.devWr = 1'b1; strb.devAux = 1'b1; end
        default: ;
      endcase
    end
  end

  // R3: the pending command is consumed by a data write
  assert_latch_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> (pendCmd == '0));
endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  kbc_strobe_t strb,
  input  byte_t       wrData,
  input  logic        kbdAvail,
  input  logic        auxAvail,
  output byte_t       statusByte,
  output logic        pushValid,
  output logic        pushAux,
  output byte_t       pushData,
  output logic        devWrValid,
  output logic        devWrAux,
  output byte_t       devWrData,
  output logic        a20Gate,
  output logic        sysResetReq,
  output logic        xlatEn,
  output logic        irqKbd,
  output logic        irqAux
);
  byte_t      modeReg;
  logic [1:0] portHi;
  logic [3:0] portLo;
  logic       selfFlag;
  logic       anyAvail, auxOnly;
  byte_t      portView;

  assign anyAvail = kbdAvail || auxAvail;
  assign auxOnly  = auxAvail && !kbdAvail;
  assign portView = {portHi, auxOnly, anyAvail, portLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= MODE_RST;
      portHi   <= PORT_RST[7:6];
      portLo   <= PORT_RST[3:0];
      selfFlag <= STAT_RST[2];
    end else begin
      if (strb.modeLoad) modeReg <= wrData;
      else               modeReg <= (modeReg | strb.modeSet) & ~strb.modeClr;
      if (strb.outLoad) begin
        portHi <= wrData[7:6];
        portLo <= wrData[3:0];
      end else if (strb.a20On)  portLo[1] <= 1'b1;
      else if (strb.a20Off)     portLo[1] <= 1'b0;
      if (strb.selfTest) selfFlag <= 1'b1;
    end
  end

  // one-cycle outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pushValid   <= 1'b0;
      pushAux     <= 1'b0;
      pushData    <= '0;
      devWrValid  <= 1'b0;
      devWrAux    <= 1'b0;
      devWrData   <= '0;
      sysResetReq <= 1'b0;
    end else begin
      pushValid   <= strb.push;
      pushAux     <= strb.pushAux;
      devWrValid  <= strb.devWr;
      devWrAux    <= strb.devAux;
      devWrData   <= wrData;
      sysResetReq <= strb.resetReq || (strb.outLoad && !wrData[0]);
      case (strb.src)
        SRC_MODE: pushData <= modeReg;
        SRC_PORT: pushData <= portView;
        SRC_TEST: pushData <= TEST_OK;
        SRC_DATA: pushData <= wrData;
        default:  pushData <= '0;
      endcase
    end
  end

  assign statusByte = {STAT_RST[7:6], auxOnly, STAT_RST[4:3], selfFlag, STAT_RST[1], anyAvail};
  assign a20Gate    = portLo[1];
  assign xlatEn     = modeReg[6];
  assign irqKbd     = kbdAvail && modeReg[0] && !modeReg[4];
  assign irqAux     = auxOnly && modeReg[1];

  assert_rst_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(strb.resetReq || (strb.outLoad && !wrData[0])));
  assert_one_sink_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pushValid, devWrValid}));
  assert_a20_up_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.a20On && !strb.outLoad) |=> a20Gate);
  assert_xlat_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeLoad |=> (xlatEn == $past(wrData[6])));
endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [7:0] wrData,
  input  logic       kbdAvail,
  input  logic       auxAvail,
  output logic [7:0] statusByte,
  output logic       pushValid,
  output logic       pushAux,
  output logic [7:0] pushData,
  output logic       devWrValid,
  output logic       devWrAux,
  output logic [7:0] devWrData,
  output logic       a20Gate,
  output logic       sysResetReq,
  output logic       xlatEn,
  output logic       irqKbd,
  output logic       irqAux
);
  kbc_strobe_t strb;

  kbc_decode u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .strb(strb)
  );

  kbc_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .kbdAvail(kbdAvail), .auxAvail(auxAvail),
    .statusByte(statusByte), .pushValid(pushValid), .pushAux(pushAux), .pushData(pushData),
    .devWrValid(devWrValid), .devWrAux(devWrAux), .devWrData(devWrData),
    .a20Gate(a20Gate), .sysResetReq(sysResetReq), .xlatEn(xlatEn),
    .irqKbd(irqKbd), .irqAux(irqAux)
  );
endmodule

// File: tb/kbc_host_port_bench.sv
module kbc_host_port_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic kbdAvail = 1'b0, auxAvail = 1'b0;
  logic [7:0] statusByte, pushData, devWrData;
  logic pushValid, pushAux, devWrValid, devWrAux, a20Gate, sysResetReq, xlatEn, irqKbd, irqAux;

  int nChecks = 0, nFails = 0;

  // reference model state
  logic [7:0] mMode, mPort, mPend;
  logic       mSelf;
  logic       kA = 1'b0, aA = 1'b0;
  logic       ePush, ePushAux, eDev, eDevAux, eRst;
  logic [7:0] ePushData, eDevData;

  always #(PERIOD/2) clk = ~clk;

  kbc_host_port u_kbc_host_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .kbdAvail(kbdAvail), .auxAvail(auxAvail), .statusByte(statusByte),
    .pushValid(pushValid), .pushAux(pushAux), .pushData(pushData),
    .devWrValid(devWrValid), .devWrAux(devWrAux), .devWrData(devWrData),
    .a20Gate(a20Gate), .sysResetReq(sysResetReq), .xlatEn(xlatEn),
    .irqKbd(irqKbd), .irqAux(irqAux)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] portView();
    return {mPort[7:6], aA && !kA, kA || aA, mPort[3:0]};
  endfunction

  task automatic checkAll();
    logic auxOnly;
    auxOnly = aA && !kA;
    chk("R11 status", statusByte, {2'b00, auxOnly, 2'b11, mSelf, 1'b0, kA || aA});
    chk("R7 irqKbd", irqKbd, kA && mMode[0] && !mMode[4]);
    chk("R11 irqAux", irqAux, auxOnly && mMode[1]);
    chk("R8 a20Gate", a20Gate, mPort[1]);
    chk("R10 xlatEn", xlatEn, mMode[6]);
    chk("R2 sysResetReq", sysResetReq, eRst);
    chk("R5 pushValid", pushValid, ePush);
    if (ePush) begin
      chk("R5 pushAux", pushAux, ePushAux);
      chk("R5 pushData", pushData, ePushData);
    end
    chk("R4 devWrValid", devWrValid, eDev);
    if (eDev) begin
      chk("R4 devWrAux", devWrAux, eDevAux);
      chk("R4 devWrData", devWrData, eDevData);
    end
  endtask

  // one clock: drive, edge, update model, compare
  task automatic step(bit w, bit s, logic [7:0] d);
    logic [7:0] c;
    @(negedge clk);
    wrEn = w; wrSel = s; wrData = d; kbdAvail = kA; auxAvail = aA;
    @(posedge clk);
    ePush = 0; ePushAux = 0; eDev = 0; eDevAux = 0; eRst = 0;
    if (w && s) begin
      c = (d[7:4] == 4'hF) ? (d[0] ? 8'hFF : 8'hFE) : d;
      case (c)
        8'h20: begin ePush = 1; ePushData = mMode; end
        8'hD0: begin ePush = 1; ePushData = portView(); end
        8'hA9, 8'hAB, 8'hC0: begin ePush = 1; ePushData = 8'h00; end
        8'hAA: begin ePush = 1; ePushData = 8'h55; mSelf = 1; end
        8'hA7: mMode[5] = 1'b1;
        8'hA8: mMode[5] = 1'b0;
        8'hAD: mMode[4] = 1'b1;
        8'hAE: mMode[4] = 1'b0;
        8'hDF: mPort[1] = 1'b1;
        8'hDD: mPort[1] = 1'b0;
        8'hFE: eRst = 1;
        8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: mPend = c;
        default: ;
      endcase
    end else if (w) begin
      case (mPend)
        8'h00: begin eDev = 1; eDevAux = 0; eDevData = d; end
        8'h60: mMode = d;
        8'hD1: begin mPort = d; eRst = !d[0]; end
        8'hD2: begin ePush = 1; ePushAux = 0; ePushData = d; end
        8'hD3: begin ePush = 1; ePushAux = 1; ePushData = d; end
        8'hD4: begin eDev = 1; eDevAux = 1; eDevData = d; end
        default: ;
      endcase
      mPend = 8'h00;
    end
    #1;
    checkAll();
  endtask

  task automatic cmd(logic [7:0] d);  step(1'b1, 1'b1, d); endtask
  task automatic dat(logic [7:0] d);  step(1'b1, 1'b0, d); endtask
  task automatic idle();              step(1'b0, 1'b0, 8'h00); endtask

  initial begin
    #(PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    mMode = 8'h03; mPort = 8'h03; mPend = 8'h00; mSelf = 1'b0;
    ePush = 0; ePushAux = 0; eDev = 0; eDevAux = 0; eRst = 0; ePushData = 0; eDevData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    #1;
    chk("R1 status at reset", statusByte, 8'h18);
    chk("R1 a20 at reset", a20Gate, 1);
    idle();
    cmd(8'h20);                      // R1/R5 mode readback 0x03
    cmd(8'hD0);                      // R1/R5 port readback 0x03
    // R7/R11 interrupt gating with queue status
    kA = 1; idle();
    cmd(8'hAD); cmd(8'hAE);
    aA = 1; idle();
    kA = 0; idle();                  // aux only
    cmd(8'hD0);                      // R5 view bits 4/5
    kA = 1; cmd(8'hD0);              // availability changes on the read edge
    kA = 0; aA = 0; idle();
    // R5 zero replies, R6 self test
    cmd(8'hA9); cmd(8'hAB); cmd(8'hC0); cmd(8'hAA); idle();
    // R7 aux disable bit
    cmd(8'hA7); cmd(8'h20); cmd(8'hA8); cmd(8'h20);
    // R8 A20
    cmd(8'hDD); cmd(8'hD0); cmd(8'hDF);
    // R2 pulse family
    for (int i = 8'hF0; i <= 8'hFF; i++) cmd(8'(i));
    cmd(8'hFE); cmd(8'hFE); idle();
    // R12 unknown codes
    cmd(8'h33); cmd(8'hA1); cmd(8'h00); cmd(8'hEF); cmd(8'h20); cmd(8'hD0);
    // R4 unarmed data write
    dat(8'h5B);
    // R3/R10 mode write, then latch cleared
    cmd(8'h60); dat(8'h47); cmd(8'h20); dat(8'h66);
    kA = 1; cmd(8'h60); dat(8'h02); // keyboard irq enable cleared while data waits
    cmd(8'h60); dat(8'h13); idle();
    cmd(8'h60); dat(8'h03);
    // R9 output port
    cmd(8'hD1); dat(8'h01);
    cmd(8'hD1); dat(8'h02); idle();
    cmd(8'hD1); dat(8'hF3); cmd(8'hD0);
    // R11 host-loaded buffers, aux device byte
    cmd(8'hD2); dat(8'h9C);
    cmd(8'hD3); dat(8'h5A);
    cmd(8'hD4); dat(8'h11);
    cmd(8'hD3); cmd(8'hD2); dat(8'hA5);  // re-arm replaces pending
    dat(8'h7E);
    kA = 0; aA = 1; idle(); kA = 1; idle(); aA = 0; idle();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule